// File: doc/BRIEF.md
# Sixteen-Pin Masked-Write GPIO Bank with Shared Interrupt

This block drives and samples sixteen general-purpose pins from a small window of 32-bit registers. Software sets each pin's direction and output level. Every external pin level passes through a two-flop synchronizer. The synchronized levels can be read back, and they also feed the interrupt outputs. Output writes carry their own per-bit mask in the upper half-word, so one store can change any subset of pins with no read-modify-write and no race against other software.

The low eight pins each raise their own active-high interrupt line, which follows the synchronized level directly. The high eight pins share one request line: each pin is gated by its own enable bit and the gated results are ORed. A two-bit control register holds the block in soft reset, stops its clock, or both. Bringing the block up means writing 3 and then 1 to that register. Writing 2 parks the block in its low-power state.

Top module: `gpio_mask_bank`

## Requirements
- R1: After the hardware reset `rstN` is released, `pinOe`, `pinOut`, `directIrq` and `sharedIrq` are all zero, and the control register at offset 0x14 reads 2: soft reset set, clock off.
- R2: The direction register at offset 0x00 holds one bit per pin in bits 15:0, where 1 means output. It drives `pinOe` from the cycle after the write and reads back its stored value.
- R3: A write to offset 0x08 changes only the pins whose mask bit in data bits 31:16 is 1, and each such pin takes the matching bit of data bits 15:0. The stored levels drive `pinOut` and read back in bits 15:0 of offset 0x08.
- R4: A read of offset 0x0C returns the pin levels after two synchronizing flops in bits 15:0, with bits 31:16 reading zero. A pin change is visible two rising edges after it is applied.
- R5: The interrupt-enable register at offset 0x10 uses bits 7:0, where bit k gates pin 8+k. `sharedIrq` is the OR over k of the synchronized pin 8+k ANDed with enable bit k.
- R6: `directIrq[k]` for k in 0..7 equals the synchronized level of pin k, with no enable gating.
- R7: The control register at offset 0x14 has bit 0 as clock enable and bit 1 as soft reset. It is always writable, reads back its value in bits 1:0, and its new value takes effect from the cycle after the write.
- R8: While soft reset is set, the direction, output and interrupt-enable registers are held at zero, whatever the clock-enable bit is, and writes to them are ignored.
- R9: While the clock-enable bit is 0, the synchronized pin levels freeze, so `directIrq` and the pin-state read hold their values, and writes to every register except the control register have no effect.
- R10: Offsets other than the five listed read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low hardware reset, synchronous |
| busAddr | input | 8 | Byte offset of the register access |
| busWrite | input | 1 | Write strobe, taken on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 16 | Asynchronous external pin levels |
| pinOut | output | 16 | Driven pin levels |
| pinOe | output | 16 | Per-pin output enable |
| directIrq | output | 8 | Per-pin interrupt for pins 0..7 |
| sharedIrq | output | 1 | Combined enabled interrupt of pins 8..15 |

## Verification
The properties assume that `pinIn` is held steady for at least the two synchronizer cycles, so that the level seen at the interrupt outputs can be traced back to the input two samples earlier. They also assume that bus strobes are only one cycle wide. The stimulus changes pins and bus signals only on falling edges, holds every pin pattern for three rising edges before sampling, and issues each write as one isolated cycle. The masked-write property observes the mask and data together in the same cycle as the strobe, and the stimulus keeps them together that way.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register offsets; software depends on these values.
  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_OUT   = 8'h08;
  localparam logic [7:0] OFS_PINS  = 8'h0C;
  localparam logic [7:0] OFS_IEN   = 8'h10;
  localparam logic [7:0] OFS_CTRL  = 8'h14;

  // Control register value after hardware reset: soft reset on, clock off.
  localparam logic [1:0] CTRL_RESET_VAL = 2'b10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrIen;
    logic clkEn;
    logic softRst;
  } dpStrobe_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else if (en) begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 16,
  parameter int IEN_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [1:0]          ctrlWdata,
  input  logic [NUM_PINS-1:0] dirQ,
  input  logic [NUM_PINS-1:0] outQ,
  input  logic [IEN_W-1:0]    ienQ,
  input  logic [NUM_PINS-1:0] pinQ,
  output dpStrobe_t           stb,
  output logic [DATA_W-1:0]   busRdata
);

  logic [1:0] ctrlQ;
  logic       hitDir, hitOut, hitPins, hitIen, hitCtrl;
  logic       regWriteOk;

  assign hitDir  = (busAddr == ADDR_W'(OFS_DIR));
  assign hitOut  = (busAddr == ADDR_W'(OFS_OUT));
  assign hitPins = (busAddr == ADDR_W'(OFS_PINS));
  assign hitIen  = (busAddr == ADDR_W'(OFS_IEN));
  assign hitCtrl = (busAddr == ADDR_W'(OFS_CTRL));

  // Control register: always writable, even with the clock stopped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET_VAL;
    end else if (busWrite && hitCtrl) begin
      ctrlQ <= ctrlWdata;
    end
  end

  assign regWriteOk = busWrite && ctrlQ[0] && !ctrlQ[1];

  always_comb begin
    stb.clkEn   = ctrlQ[0];
    stb.softRst = ctrlQ[1];
    stb.wrDir   = regWriteOk && hitDir;
    stb.wrOut   = regWriteOk && hitOut;
    stb.wrIen   = regWriteOk && hitIen;
  end

  always_comb begin
    busRdata = '0;
    if (hitDir)  busRdata[NUM_PINS-1:0] = dirQ;
    if (hitOut)  busRdata[NUM_PINS-1:0] = outQ;
    if (hitPins) busRdata[NUM_PINS-1:0] = pinQ;
    if (hitIen)  busRdata[IEN_W-1:0]    = ienQ;
    if (hitCtrl) busRdata[1:0]          = ctrlQ;
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_PINS    = 16,
  parameter int SHARED_LO   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IEN_W      = NUM_PINS - SHARED_LO,
  localparam int MASK_LSB   = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  dirQ,
  output logic [NUM_PINS-1:0]  outQ,
  output logic [IEN_W-1:0]     ienQ,
  output logic [NUM_PINS-1:0]  pinQ,
  output logic [SHARED_LO-1:0] directIrq,
  output logic                 sharedIrq
);

  logic [NUM_PINS-1:0] wrMask;
  logic [NUM_PINS-1:0] wrVal;

  assign wrMask = wdata[MASK_LSB +: NUM_PINS];
  assign wrVal  = wdata[NUM_PINS-1:0];

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .en   (stb.clkEn),
    .din  (pinIn),
    .dout (pinQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN || stb.softRst) begin
      dirQ <= '0;
    end else if (stb.wrDir) begin
      dirQ <= wrVal;
    end
  end

  // Per-pin masked update of the output levels.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_outBit
    always_ff @(posedge clk) begin
      if (!rstN || stb.softRst) begin
        outQ[i] <= 1'b0;
      end else if (stb.wrOut && wrMask[i]) begin
        outQ[i] <= wrVal[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.softRst) begin
      ienQ <= '0;
    end else if (stb.wrIen) begin
      ienQ <= wdata[IEN_W-1:0];
    end
  end

  assign directIrq = pinQ[SHARED_LO-1:0];
  assign sharedIrq = |(pinQ[NUM_PINS-1:SHARED_LO] & ienQ);

endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_PINS    = 16,
  parameter int SHARED_LO   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrite,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe,
  output logic [SHARED_LO-1:0] directIrq,
  output logic                 sharedIrq
);

  localparam int IEN_W = NUM_PINS - SHARED_LO;

  dpStrobe_t           dpStb;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] outQ;
  logic [IEN_W-1:0]    ienQ;
  logic [NUM_PINS-1:0] pinQ;

  gpio_bank_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .IEN_W(IEN_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .ctrlWdata (busWdata[1:0]),
    .dirQ      (dirQ),
    .outQ      (outQ),
    .ienQ      (ienQ),
    .pinQ      (pinQ),
    .stb       (dpStb),
    .busRdata  (busRdata)
  );

  gpio_bank_dp #(
    .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .SHARED_LO(SHARED_LO),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (dpStb),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .dirQ      (dirQ),
    .outQ      (outQ),
    .ienQ      (ienQ),
    .pinQ      (pinQ),
    .directIrq (directIrq),
    .sharedIrq (sharedIrq)
  );

  assign pinOut = outQ;
  assign pinOe  = dirQ;

endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_PINS  = 16,
  parameter int SHARED_LO = 8,
  localparam int MASK_LSB = DATA_W / 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrite,
  input logic [DATA_W-1:0]    busWdata,
  input logic [NUM_PINS-1:0]  pinIn,
  input logic [NUM_PINS-1:0]  pinOut,
  input logic [NUM_PINS-1:0]  pinOe,
  input logic [SHARED_LO-1:0] directIrq,
  input logic                 sharedIrq,
  input logic                 clkEn,
  input logic                 softRst
);

  logic outWrite;
  assign outWrite = busWrite && (busAddr == ADDR_W'(8'h08)) && clkEn && !softRst;

  // R3: only masked pins change, to the written level
  p_masked_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |=> pinOut == (($past(pinOut) & ~$past(busWdata[MASK_LSB +: NUM_PINS]))
                         | ($past(busWdata[NUM_PINS-1:0]) & $past(busWdata[MASK_LSB +: NUM_PINS]))));

  // R8: soft reset clears the driven state
  p_soft_reset_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (pinOe == '0) && (pinOut == '0) && !sharedIrq);

  // R9: clock off freezes outputs and direct interrupts
  p_clock_off_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !softRst) |=> $stable(pinOe) && $stable(pinOut) && $stable(directIrq));

  // R6: direct interrupts follow the pin two samples back
  p_direct_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkEn, 1) && $past(clkEn, 2)) |-> directIrq == $past(pinIn[SHARED_LO-1:0], 2));

  // R5: shared request needs some high pin in the upper group
  p_shared_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkEn, 1) && $past(clkEn, 2) && sharedIrq) |-> |$past(pinIn[NUM_PINS-1:SHARED_LO], 2));

endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .SHARED_LO(SHARED_LO)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrite  (busWrite),
  .busWdata  (busWdata),
  .pinIn     (pinIn),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .directIrq (directIrq),
  .sharedIrq (sharedIrq),
  .clkEn     (dpStb.clkEn),
  .softRst   (dpStb.softRst)
);

// File: tb/gpio_mask_bank_tb_top.sv
module gpio_mask_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic [15:0] pinOe;
  logic [7:0]  directIrq;
  logic        sharedIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mask_bank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .directIrq(directIrq), .sharedIrq(sharedIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #2;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] expOut;
    logic [31:0] lcg;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 pinOe", 32'(pinOe), 32'h0);
    chk("R1 pinOut", 32'(pinOut), 32'h0);
    chk("R1 directIrq", 32'(directIrq), 32'h0);
    chk("R1 sharedIrq", 32'(sharedIrq), 32'h0);
    rd(8'h14, r); chk("R1 ctrl", r, 32'h2);

    // R8 writes ignored while held in reset
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, r); chk("R8 dir in reset", r, 32'h0);

    // R7 bring-up sequence
    wr(8'h14, 32'h3);
    rd(8'h14, r); chk("R7 ctrl=3", r, 32'h3);
    wr(8'h14, 32'h1);
    rd(8'h14, r); chk("R7 ctrl=1", r, 32'h1);

    // R2 direction sweep over single bits and patterns
    for (int i = 0; i < 18; i++) begin
      logic [15:0] d;
      d = (i < 16) ? 16'(1 << i) : ((i == 16) ? 16'hA5A5 : 16'h0F0F);
      wr(8'h00, {16'hFFFF, d});
      rd(8'h00, r);
      chk("R2 dir readback", r, {16'h0, d});
      chk("R2 pinOe", 32'(pinOe), 32'(d));
    end

    // R3 masked output writes
    expOut = 16'h0;
    wr(8'h08, 32'hFFFF_0000);
    lcg = 32'h1234_5678;
    for (int i = 0; i < 64; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      wr(8'h08, lcg);
      expOut = (expOut & ~lcg[31:16]) | (lcg[15:0] & lcg[31:16]);
      chk("R3 pinOut", 32'(pinOut), 32'(expOut));
      rd(8'h08, r);
      chk("R3 out readback", r, 32'(expOut));
    end
    wr(8'h08, 32'h0000_FFFF);
    chk("R3 zero mask no change", 32'(pinOut), 32'(expOut));

    // R4 and R6 sweep of the low byte with varied high byte
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pinIn = {8'(v * 37 + 5), 8'(v)};
      settle();
      chk("R6 directIrq", 32'(directIrq), 32'(v));
      rd(8'h0C, r);
      chk("R4 pin state", r, {16'h0, pinIn});
    end

    // R5 shared interrupt sweep over every enable value
    for (int e = 0; e < 256; e++) begin
      wr(8'h10, 32'(e) | 32'hFFFF_FF00);
      rd(8'h10, r);
      chk("R5 ien readback", r, 32'(e));
      for (int p = 0; p < 256; p += 17) begin
        @(negedge clk);
        pinIn = {8'(p), 8'h00};
        settle();
        chk("R5 sharedIrq", 32'(sharedIrq), 32'(|(8'(p) & 8'(e))));
      end
    end

    // R10 unmapped offsets
    wr(8'h00, 32'h0000_3C3C);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h04, r); chk("R10 read 0x04", r, 32'h0);
    rd(8'h18, r); chk("R10 read 0x18", r, 32'h0);
    chk("R10 dir untouched", 32'(pinOe), 32'h3C3C);
    chk("R10 out untouched", 32'(pinOut), 32'(expOut));
    rd(8'h14, r); chk("R10 ctrl untouched", r, 32'h1);

    // R9 clock stopped
    @(negedge clk);
    pinIn = 16'hA5C3;
    settle();
    wr(8'h14, 32'h0);
    @(negedge clk);
    pinIn = 16'h5A3C;
    repeat (4) @(posedge clk);
    rd(8'h0C, r); chk("R9 pin state frozen", r, 32'h0000_A5C3);
    chk("R9 directIrq frozen", 32'(directIrq), 32'hC3);
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, r); chk("R9 dir write ignored", r, 32'h3C3C);
    wr(8'h08, 32'hFFFF_0000 | 32'(~expOut));
    chk("R9 out write ignored", 32'(pinOut), 32'(expOut));
    rd(8'h14, r); chk("R9 ctrl writable", r, 32'h0);

    // R8 soft reset with clock running
    wr(8'h10, 32'hFF);
    wr(8'h14, 32'h3);
    @(negedge clk);
    pinIn = 16'hFF00;
    settle();
    chk("R8 pinOe", 32'(pinOe), 32'h0);
    chk("R8 pinOut", 32'(pinOut), 32'h0);
    chk("R8 sharedIrq", 32'(sharedIrq), 32'h0);
    rd(8'h10, r); chk("R8 ien", r, 32'h0);
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, r); chk("R8 dir write ignored", r, 32'h0);
    rd(8'h0C, r); chk("R4 pin state live in reset", r, 32'h0000_FF00);
    wr(8'h14, 32'h1);
    wr(8'h00, 32'h0000_00F0);
    rd(8'h00, r); chk("R7 dir writable after release", r, 32'h0000_00F0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule